// File: doc/BRIEF.md
# Synchronous Serial Clock Router

This block produces and steers the clocks for an attached synchronous serial controller. A free-running counter on the master oscillator gives four divided rates. For each direction, transmit and receive, the block places one of the following on that direction's clock pin: the divided clock, an off-board clock input, the raw oscillator, or a constant low. It also gates the master clock fed to the controller. It can release its driver on the transmit-clock pin so that the controller may drive that pin itself.

Software sets all of this through one 8-bit control register. The register is written with a single write strobe and always reads back. A new rate code does not take effect straight away. It waits for the next wrap of the divider counter, where every tap is at the same level, so the divided clock never produces a short pulse. One enable bit has two jobs. When a direction selects an external source, that bit picks between the off-board input and the raw oscillator. When a direction selects the divided clock, that bit gates it.

The rate logic is a two-state machine:
- `RATE_LOCKED`: the active rate equals the requested rate.
- `RATE_PENDING`: a new code waits for the wrap.

Transitions:
- LOCKED to PENDING when the request differs and the counter is not at its last count.
- PENDING to LOCKED at the wrap, where the requested code is loaded.
- If the request differs while the counter is already at its last count, the code is loaded directly and the state stays LOCKED.

Top module: `clk_router`

## Requirements
- R1: After reset the control register reads 0x00. A write strobe stores the write data at the next rising edge, and the stored value is presented on the read port from then on.
- R2: Control bits [1:0] select the divided clock. It equals bit (code+1) of a 5-bit count of master edges since reset: code 0 divides by 4, code 1 by 8, code 2 by 16 and code 3 by 32.
- R3: A new rate code is adopted only at the edge where the 5-bit counter wraps from 31 to 0. Until then the previous code stays in use.
- R4: Control bit 3 low uses the rising-edge counter for the divided clock. Bit 3 high uses a separate counter that advances on falling edges.
- R5: The controller master clock follows the oscillator when control bit 4 is set and is held low otherwise. The gate enable is captured on falling edges.
- R6: With control bit 5 low, a direction whose select bit is low drives its clock pin low.
- R7: With control bit 5 high, a direction whose select bit is low drives the divided clock. The transmit select is bit 6 and the receive select is bit 7.
- R8: With control bit 5 high, a direction whose select bit is high drives its off-board clock input.
- R9: With control bit 5 low, a direction whose select bit is high drives the raw oscillator.
- R10: With control bit 2 high, the transmit pad carries the transmit clock and the driver-enable output is high. With bit 2 low, the pad is high-impedance and the driver-enable output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Master oscillator, also the register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read-back |
| ext_tx_clk | input | 1 | Off-board transmit clock input |
| ext_rx_clk | input | 1 | Off-board receive clock input |
| ctrl_mclk | output | 1 | Gated master clock to the controller |
| rx_clk | output | 1 | Receive clock pin |
| tx_clk_pad | output | 1 | Transmit clock pin, tri-stated when not driven |
| tx_drv_en | output | 1 | High while the transmit clock driver is on |

## Verification
Register writes and the rising-edge counter settle one rising edge after the stimulus. The falling-edge counter and the master-clock gate settle at the following falling edge. The pin multiplexing is combinational on top of that state, so a change in the oscillator or an external input shows on a pin with no delay. The bench keeps a behavioural model that is updated on both clock edges. It compares every output 1 ns after each rising edge, with the oscillator high, and 1 ns after each falling edge, with the oscillator low. In this way both levels of the raw-oscillator and gated-clock paths are covered. The rate code is rewritten at arbitrary counter phases, so the wrap-only switching is compared in each cycle.

// File: rtl/clkr_pkg.sv
package clkr_pkg;

    // Width of the rate code and log2 of the smallest division
    localparam int RATE_W       = 2;
    localparam int DIV_MIN_LOG2 = 2;

    // Direction indices for the per-pin selectors
    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;
    localparam int N_DIRS = 2;

    typedef enum logic [0:0] {
        RATE_LOCKED  = 1'b0,
        RATE_PENDING = 1'b1
    } rate_state_e;

    // Control register layout, most significant bit first
    typedef struct packed {
        logic              rx_ext;    // bit 7
        logic              tx_ext;    // bit 6
        logic              clk_en;    // bit 5
        logic              mclk_en;   // bit 4
        logic              neg_edge;  // bit 3
        logic              drv_en;    // bit 2
        logic [RATE_W-1:0] rate;      // bits 1:0
    } clkr_cfg_t;

endpackage

// File: rtl/clkr_divider.sv
module clkr_divider
    import clkr_pkg::*;
#(
    parameter int P_RATE_W  = RATE_W,
    parameter int P_MIN_LOG = DIV_MIN_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_RATE_W-1:0] rate_req,
    input  logic                neg_edge,
    output logic                div_clk
);

    localparam int N_RATES = 1 << P_RATE_W;
    localparam int CNT_W   = P_MIN_LOG + N_RATES - 1;

    logic [CNT_W-1:0]    cnt_r;
    logic [CNT_W-1:0]    cnt_f;
    logic [P_RATE_W-1:0] rate_q;
    logic [P_RATE_W-1:0] rate_d;
    rate_state_e         state_q;
    rate_state_e         state_d;
    logic                wrap;
    logic [N_RATES-1:0]  taps_r;
    logic [N_RATES-1:0]  taps_f;

    assign wrap = &cnt_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_r <= '0;
        else        cnt_r <= cnt_r + 1'b1;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cnt_f <= '0;
        else        cnt_f <= cnt_f + 1'b1;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RATE_LOCKED;
            rate_q  <= '0;
        end else begin
            state_q <= state_d;
            rate_q  <= rate_d;
        end
    end

    // Next state and loaded rate
    always_comb begin
        state_d = state_q;
        rate_d  = rate_q;
        unique case (state_q)
            RATE_LOCKED: begin
                if (rate_req != rate_q) begin
                    if (wrap) rate_d  = rate_req;
                    else      state_d = RATE_PENDING;
                end
            end
            RATE_PENDING: begin
                if (wrap) begin
                    rate_d  = rate_req;
                    state_d = RATE_LOCKED;
                end
            end
            default: state_d = RATE_LOCKED;
        endcase
    end

    generate
        for (genvar i = 0; i < N_RATES; i++) begin : g_tap
            assign taps_r[i] = cnt_r[P_MIN_LOG - 1 + i];
            assign taps_f[i] = cnt_f[P_MIN_LOG - 1 + i];
        end
    endgenerate

    assign div_clk = neg_edge ? taps_f[rate_q] : taps_r[rate_q];

endmodule

// File: rtl/clkr_pin_sel.sv
module clkr_pin_sel (
    input  logic osc,
    input  logic div_clk,
    input  logic ext_clk,
    input  logic clk_en,
    input  logic use_ext,
    output logic pin_clk
);

    always_comb begin
        unique case ({use_ext, clk_en})
            2'b00:   pin_clk = 1'b0;
            2'b01:   pin_clk = div_clk;
            2'b10:   pin_clk = osc;
            2'b11:   pin_clk = ext_clk;
            default: pin_clk = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkr_mclk_gate.sv
module clkr_mclk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic gclk
);

    logic en_low_q;

    // Enable taken while the clock is low, so the AND cannot chop a pulse
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_low_q <= 1'b0;
        else        en_low_q <= en;
    end

    assign gclk = clk & en_low_q;

endmodule

// File: rtl/clk_router.sv
module clk_router
    import clkr_pkg::*;
(
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       ext_tx_clk,
    input  logic       ext_rx_clk,
    output logic       ctrl_mclk,
    output logic       rx_clk,
    output logic       tx_clk_pad,
    output logic       tx_drv_en
);

    clkr_cfg_t         cfg_q;
    logic              div_clk;
    logic [N_DIRS-1:0] ext_in;
    logic [N_DIRS-1:0] sel_ext;
    logic [N_DIRS-1:0] pin_out;

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= clkr_cfg_t'(cfg_wdata);
    end

    assign cfg_rdata = cfg_q;

    clkr_divider u_div (
        .clk      (clk_osc),
        .rst_n    (rst_n),
        .rate_req (cfg_q.rate),
        .neg_edge (cfg_q.neg_edge),
        .div_clk  (div_clk)
    );

    clkr_mclk_gate u_mgate (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .en    (cfg_q.mclk_en),
        .gclk  (ctrl_mclk)
    );

    assign ext_in[DIR_TX]  = ext_tx_clk;
    assign ext_in[DIR_RX]  = ext_rx_clk;
    assign sel_ext[DIR_TX] = cfg_q.tx_ext;
    assign sel_ext[DIR_RX] = cfg_q.rx_ext;

    generate
        for (genvar d = 0; d < N_DIRS; d++) begin : g_dir
            clkr_pin_sel u_sel (
                .osc     (clk_osc),
                .div_clk (div_clk),
                .ext_clk (ext_in[d]),
                .clk_en  (cfg_q.clk_en),
                .use_ext (sel_ext[d]),
                .pin_clk (pin_out[d])
            );
        end
    endgenerate

    assign rx_clk     = pin_out[DIR_RX];
    assign tx_drv_en  = cfg_q.drv_en;
    assign tx_clk_pad = cfg_q.drv_en ? pin_out[DIR_TX] : 1'bz;

endmodule

// File: rtl/clkr_chk.sv
module clkr_chk (
    input logic       clk_osc,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       ext_rx_clk,
    input logic       ctrl_mclk,
    input logic       rx_clk,
    input logic       tx_drv_en
);

    AST_CFG_READBACK: assert property (@(posedge clk_osc) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == $past(cfg_wdata)); // R1

    AST_MCLK_HELD_LOW: assert property (@(negedge clk_osc) disable iff (!rst_n)
        !cfg_rdata[4] |=> !ctrl_mclk); // R5

    AST_MCLK_PASSES: assert property (@(negedge clk_osc) disable iff (!rst_n)
        cfg_rdata[4] |=> ctrl_mclk); // R5

    AST_RX_PIN_OFF: assert property (@(negedge clk_osc) disable iff (!rst_n)
        (!cfg_rdata[5] && !cfg_rdata[7]) |-> !rx_clk); // R6

    AST_RX_EXT_ROUTE: assert property (@(negedge clk_osc) disable iff (!rst_n)
        (cfg_rdata[5] && cfg_rdata[7]) |-> rx_clk == ext_rx_clk); // R8

    AST_RX_OSC_ROUTE: assert property (@(negedge clk_osc) disable iff (!rst_n)
        (!cfg_rdata[5] && cfg_rdata[7]) |-> rx_clk); // R9

    AST_DRIVER_OFF: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !cfg_rdata[2] |-> !tx_drv_en); // R10

endmodule

bind clk_router clkr_chk chk_i (
    .clk_osc    (clk_osc),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .ext_rx_clk (ext_rx_clk),
    .ctrl_mclk  (ctrl_mclk),
    .rx_clk     (rx_clk),
    .tx_drv_en  (tx_drv_en)
);

// File: tb/clk_router_tb.sv
module clk_router_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       ext_tx = 1'b0;
    logic       ext_rx = 1'b0;
    wire  [7:0] cfg_rdata;
    wire        ctrl_mclk;
    wire        rx_clk;
    wire        tx_clk_pad;
    wire        tx_drv_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [7:0] m_cfg = 8'h00;
    int         m_pcnt = 0;
    int         m_ncnt = 0;
    int         m_rate = 0;
    logic       m_men = 1'b0;

    clk_router dut_i (
        .clk_osc    (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .ext_tx_clk (ext_tx),
        .ext_rx_clk (ext_rx),
        .ctrl_mclk  (ctrl_mclk),
        .rx_clk     (rx_clk),
        .tx_clk_pad (tx_clk_pad),
        .tx_drv_en  (tx_drv_en)
    );

    always #4 clk = ~clk;

    initial #1 rst_n = 1'b0;

    // Model: rising-edge part (R1, R2, R3)
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg  = 8'h00;
            m_pcnt = 0;
            m_rate = 0;
        end else begin
            if (m_pcnt == 31) m_rate = m_cfg[1:0];
            m_pcnt = (m_pcnt + 1) % 32;
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    // Model: falling-edge part (R4, R5)
    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ncnt = 0;
            m_men  = 1'b0;
        end else begin
            m_ncnt = (m_ncnt + 1) % 32;
            m_men  = m_cfg[4];
        end
    end

    // Off-board clocks at unrelated slow rates
    always @(negedge clk) begin
        #2;
        if ($urandom_range(0, 2) == 0) ext_tx = ~ext_tx;
        if ($urandom_range(0, 4) == 0) ext_rx = ~ext_rx;
    end

    function automatic logic tap(int c);
        return logic'((c >> (m_rate + 1)) & 1);
    endfunction

    function automatic logic pin_exp(logic sel, logic ext, logic osc);
        logic dv;
        dv = m_cfg[3] ? tap(m_ncnt) : tap(m_pcnt);
        if (sel) return m_cfg[5] ? ext : osc;
        return m_cfg[5] ? dv : 1'b0;
    endfunction

    function automatic string mode_tag(logic sel);
        if (!sel && !m_cfg[5]) return "R6";
        if (!sel)              return "R7 R2 R3 R4";
        if (m_cfg[5])          return "R8";
        return "R9";
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare(logic osc);
        logic tx_exp;
        checks++;
        if (cfg_rdata !== m_cfg) begin
            errors++;
            $display("FAIL R1: actual %h expected %h at %0t", cfg_rdata, m_cfg, $time);
        end
        chk("R5", ctrl_mclk, osc ? m_men : 1'b0);
        chk(mode_tag(m_cfg[7]), rx_clk, pin_exp(m_cfg[7], ext_rx, osc));
        tx_exp = pin_exp(m_cfg[6], ext_tx, osc);
        chk({"R10 ", mode_tag(m_cfg[6])}, tx_clk_pad, m_cfg[2] ? tx_exp : 1'bz);
        chk("R10", tx_drv_en, m_cfg[2]);
    endtask

    always @(posedge clk) begin
        #1;
        if (!finished) compare(1'b1);
    end

    always @(negedge clk) begin
        #1;
        if (!finished) compare(1'b0);
    end

    task automatic wr(logic [7:0] v);
        @(negedge clk);
        #2;
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        #2;
        cfg_we    = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        // R1 reset state is checked while reset is held
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        run(20);
        wr(8'h20); run(90);   // R7 at rate code 0
        wr(8'h25); run(70);   // R2 code 1 with the driver on, R10
        wr(8'h26); run(13);   // R3 code changes before the wrap
        wr(8'h27); run(110);
        wr(8'h2C); run(90);   // R4 falling-edge counter
        wr(8'h2F); run(90);
        wr(8'h14); run(40);   // R5 master clock on, R6 pins low
        wr(8'h64); run(80);   // R8 transmit external
        wr(8'hA5); run(80);   // R8 receive external, transmit divided
        wr(8'hE4); run(60);
        wr(8'hC4); run(40);   // R9 raw oscillator on both pins
        wr(8'h40); run(30);   // R10 pad released
        wr(8'h00); run(30);   // R5 master clock off
        for (int i = 0; i < 12; i++) begin
            wr(8'(i * 37 + 5)); run(7 + i * 5);
        end
        summary();
    end

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

endmodule